// File: doc/BRIEF.md
# Keyed-Service System Watchdog

This block is a system watchdog that counts clock cycles while it is enabled and takes a configurable action when software fails to service it in time. Software sets it up through a control word carrying an enable bit, a timeout selector and an action selector. The count restarts only when software writes an ordered pair of key values to a separate service register. A single stray write cannot keep a runaway program alive.

On expiry the block raises one of three responses: a level interrupt request, a level fast-interrupt request, or a one-cycle reset request for an external reset controller. Both writes arrive on one narrow write port. A one-bit select chooses between the control word and the service register. The four timeout lengths are powers of two set by parameters, so a bench can shrink them to a few cycles.

Top module: `wdt_guard`

## Requirements
- R1: While the enable bit (control bit 0) is 0, the cycle count is held at zero and irq_o, fiq_o and rst_req_o stay low. Writing enable 0 clears any held request at that same edge. Setting enable starts the count from zero.
- R2: The timeout selector (control bits 4:3) picks the period: 00 gives 2^EXP_A cycles, 01 gives 2^EXP_B, 10 gives 2^EXP_C and 11 gives 2^EXP_D. The expiry output appears exactly that many clock edges after the enabling write or the last restart.
- R3: The action selector is control bits 2:1. With 00 the expiry sets irq_o, and with 01 it sets fiq_o. The request stays high until a valid service sequence or a disable.
- R4: With action 10 or 11, the expiry gives rst_req_o for exactly one cycle. The count then restarts from zero, so pulses repeat once every period until the block is serviced.
- R5: A write of KEY_A (0x123) to the service register (wr_sel=1), followed by a write of KEY_B (0x321) as the next service write, restarts the count from zero and clears irq_o and fiq_o at the edge of the second write.
- R6: A KEY_B service write that does not directly follow a KEY_A service write does not restart the count, and it leaves the key tracker idle.
- R7: A service write of any value other than the two keys cancels a pending KEY_A.
- R8: Repeated KEY_A writes keep the tracker armed, so KEY_A, KEY_A, KEY_B is a valid service.
- R9: Control writes (wr_sel=0) do not disturb the key tracker. A control write that keeps the block enabled does not restart the count.
- R10: When a valid service completes in the same cycle as the final count of a period, the service wins. No expiry output appears, and the next period starts from that service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the service register |
| wr_data | input | DATA_W | Write data |
| irq_o | output | 1 | Held interrupt request on expiry |
| fiq_o | output | 1 | Held fast-interrupt request on expiry |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The final cycle of a period and the completion of a service sequence can fall in the same cycle. The bench provokes this by timing the second key write so that its edge is the edge at which the interrupt request would otherwise be set. It expects irq_o to stay low at that edge. It then expects irq_o to stay low for one full period more and to rise on the edge after that, which shows that the period restarted from the service.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control word field positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_ACT_LSB  = 1;
    localparam int CTL_TSEL_LSB = 3;

    typedef enum logic [1:0] {
        ACT_IRQ  = 2'b00,
        ACT_FIQ  = 2'b01,
        ACT_RST  = 2'b10,
        ACT_RST3 = 2'b11
    } wdt_act_e;

    typedef struct packed {
        logic       en;
        wdt_act_e   act;
        logic [1:0] tsel;
    } wdt_ctrl_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } wdt_key_e;

    typedef struct packed {
        logic irq;
        logic fiq;
        logic rst;
    } wdt_out_t;

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY_A = 16'h0123,
    parameter logic [DATA_W-1:0] KEY_B = 16'h0321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              armed_o,
    output logic              kick_o
);

    wdt_key_e state_d, state_q;
    logic     kick_d;

    always_comb begin
        state_d = state_q;
        kick_d  = 1'b0;
        if (svc_wr_i) begin
            if (data_i == KEY_A) begin
                state_d = KS_ARMED;
            end else if (data_i == KEY_B) begin
                kick_d  = (state_q == KS_ARMED);
                state_d = KS_IDLE;
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign armed_o = (state_q == KS_ARMED);
    assign kick_o  = kick_d;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int EXP_A = 24,
    parameter int EXP_B = 26,
    parameter int EXP_C = 28,
    parameter int EXP_D = 29,
    parameter int CNT_W = EXP_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q_i,
    input  logic             en_d_i,
    input  logic [1:0]       tsel_i,
    input  logic             restart_i,
    output logic             term_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int NUM_SEL = 4;
    localparam int EXPS [NUM_SEL] = '{EXP_A, EXP_B, EXP_C, EXP_D};

    logic [CNT_W-1:0] lim [NUM_SEL];
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             term;

    for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_lim
        assign lim[gi] = {CNT_W{1'b1}} >> (CNT_W - EXPS[gi]);
    end

    assign term = en_q_i && (cnt_q >= lim[tsel_i]);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!en_q_i || !en_d_i || restart_i || term) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign term_o = term;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_d_i,
    input  wdt_act_e act_i,
    input  logic     expire_i,
    input  logic     kick_i,
    output logic     irq_o,
    output logic     fiq_o,
    output logic     rst_req_o
);

    wdt_out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.rst = 1'b0;
        if (kick_i) begin
            out_d.irq = 1'b0;
            out_d.fiq = 1'b0;
        end
        if (expire_i) begin
            unique case (act_i)
                ACT_IRQ:           out_d.irq = 1'b1;
                ACT_FIQ:           out_d.fiq = 1'b1;
                ACT_RST, ACT_RST3: out_d.rst = 1'b1;
                default:           out_d.rst = 1'b1;
            endcase
        end
        if (!en_d_i) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o     = out_q.irq;
    assign fiq_o     = out_q.fiq;
    assign rst_req_o = out_q.rst;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY_A  = 16'h0123,
    parameter logic [DATA_W-1:0] KEY_B  = 16'h0321,
    parameter int                EXP_A  = 24,
    parameter int                EXP_B  = 26,
    parameter int                EXP_C  = 28,
    parameter int                EXP_D  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              rst_req_o
);

    localparam int CNT_W = EXP_D;

    wdt_ctrl_t        ctrl_d, ctrl_q;
    logic             ctl_wr, svc_wr;
    logic             kick, armed, term, expire;
    logic [CNT_W-1:0] cnt;

    assign ctl_wr = wr_en && !wr_sel;
    assign svc_wr = wr_en &&  wr_sel;

    // Control word register
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctl_wr) begin
            ctrl_d.en   = wr_data[CTL_EN_BIT];
            ctrl_d.act  = wdt_act_e'(wr_data[CTL_ACT_LSB +: 2]);
            ctrl_d.tsel = wr_data[CTL_TSEL_LSB +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{en: 1'b0, act: ACT_IRQ, tsel: 2'b00};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    wdt_keyseq #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr_i (svc_wr),
        .data_i   (wr_data),
        .armed_o  (armed),
        .kick_o   (kick)
    );

    wdt_counter #(
        .EXP_A (EXP_A),
        .EXP_B (EXP_B),
        .EXP_C (EXP_C),
        .EXP_D (EXP_D),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_q_i    (ctrl_q.en),
        .en_d_i    (ctrl_d.en),
        .tsel_i    (ctrl_q.tsel),
        .restart_i (kick),
        .term_o    (term),
        .cnt_o     (cnt)
    );

    // A service completing on the final count wins over the expiry
    assign expire = term && !kick;

    wdt_action u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_d_i    (ctrl_d.en),
        .act_i     (ctrl_q.act),
        .expire_i  (expire),
        .kick_i    (kick),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .rst_req_o (rst_req_o)
    );

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY_A  = 16'h0123,
    parameter int                CNT_W  = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              svc_wr,
    input logic [DATA_W-1:0] wr_data,
    input logic              en_q,
    input logic              kick,
    input logic              armed,
    input logic              term,
    input logic [CNT_W-1:0]  cnt,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              rst_req_o
);

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (cnt == '0 && !irq_o && !fiq_o && !rst_req_o));

    p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(kick) || !en_q));

    p_fiq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fiq_o) |-> ($past(kick) || !en_q));

    p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    p_rst_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(term));

    p_kick_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0 && !irq_o && !fiq_o));

    p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && wr_data != KEY_A) |=> !armed);

    p_key_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && wr_data == KEY_A) |=> armed);

    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && term) |=> (!irq_o && !fiq_o && !rst_req_o));

endmodule

bind wdt_guard wdt_guard_chk #(
    .DATA_W (DATA_W),
    .KEY_A  (KEY_A),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_wr    (svc_wr),
    .wr_data   (wr_data),
    .en_q      (ctrl_q.en),
    .kick      (kick),
    .armed     (armed),
    .term      (term),
    .cnt       (cnt),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;

    localparam int DATA_W = 16;
    localparam int NVEC   = 48;
    // Vector: kind[28:27] (0 idle, 1 control, 2 service), data[26:15],
    // gap[14:7] idle edges before sampling, expect {irq,fiq,rst}[6:4], req[3:0]
    localparam logic [28:0] VEC [NVEC] = '{
        {2'd1, 12'h001, 8'd7,  3'b000, 4'd2},  // R2 enable IRQ, 8-cycle period
        {2'd0, 12'h000, 8'd1,  3'b100, 4'd2},  // R2 expiry on edge 8
        {2'd0, 12'h000, 8'd20, 3'b100, 4'd3},  // R3 held
        {2'd2, 12'h123, 8'd0,  3'b100, 4'd5},
        {2'd2, 12'h321, 8'd0,  3'b000, 4'd5},  // R5 cleared
        {2'd0, 12'h000, 8'd7,  3'b000, 4'd5},
        {2'd0, 12'h000, 8'd1,  3'b100, 4'd5},  // R5 period from service
        {2'd2, 12'h321, 8'd3,  3'b100, 4'd6},  // R6 lone second key
        {2'd2, 12'h321, 8'd0,  3'b100, 4'd6},
        {2'd2, 12'h123, 8'd0,  3'b100, 4'd7},
        {2'd2, 12'h055, 8'd0,  3'b100, 4'd7},
        {2'd2, 12'h321, 8'd0,  3'b100, 4'd7},  // R7 cancelled
        {2'd2, 12'h123, 8'd0,  3'b100, 4'd8},
        {2'd2, 12'h123, 8'd0,  3'b100, 4'd8},
        {2'd2, 12'h321, 8'd0,  3'b000, 4'd8},  // R8 double first key
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},  // R1 disable
        {2'd0, 12'h000, 8'd100,3'b000, 4'd1},
        {2'd1, 12'h003, 8'd7,  3'b000, 4'd3},  // R3 FIQ
        {2'd0, 12'h000, 8'd1,  3'b010, 4'd3},
        {2'd0, 12'h000, 8'd9,  3'b010, 4'd3},
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},  // R1 disable clears held FIQ
        {2'd1, 12'h005, 8'd7,  3'b000, 4'd4},  // R4 reset action
        {2'd0, 12'h000, 8'd1,  3'b001, 4'd4},
        {2'd0, 12'h000, 8'd1,  3'b000, 4'd4},
        {2'd0, 12'h000, 8'd6,  3'b000, 4'd4},
        {2'd0, 12'h000, 8'd1,  3'b001, 4'd4},  // R4 repeats
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},
        {2'd1, 12'h007, 8'd7,  3'b000, 4'd4},  // R4 action 11
        {2'd0, 12'h000, 8'd1,  3'b001, 4'd4},
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},
        {2'd1, 12'h009, 8'd15, 3'b000, 4'd2},  // R2 16-cycle
        {2'd0, 12'h000, 8'd1,  3'b100, 4'd2},
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},
        {2'd1, 12'h013, 8'd31, 3'b000, 4'd2},  // R2 32-cycle FIQ
        {2'd0, 12'h000, 8'd1,  3'b010, 4'd2},
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},
        {2'd1, 12'h019, 8'd63, 3'b000, 4'd2},  // R2 64-cycle
        {2'd0, 12'h000, 8'd1,  3'b100, 4'd2},
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},
        {2'd1, 12'h001, 8'd0,  3'b000, 4'd9},  // R9 control between keys
        {2'd2, 12'h123, 8'd0,  3'b000, 4'd9},
        {2'd1, 12'h001, 8'd0,  3'b000, 4'd9},
        {2'd2, 12'h321, 8'd7,  3'b000, 4'd9},
        {2'd0, 12'h000, 8'd1,  3'b100, 4'd9},
        {2'd1, 12'h000, 8'd0,  3'b000, 4'd1},
        {2'd1, 12'h001, 8'd3,  3'b000, 4'd9},  // R9 rewrite keeps count
        {2'd1, 12'h001, 8'd3,  3'b000, 4'd9},
        {2'd0, 12'h000, 8'd1,  3'b100, 4'd9}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              irq_o, fiq_o, rst_req_o;
    int                checks = 0;
    int                errors = 0;

    always #5 clk = ~clk;

    wdt_guard #(
        .DATA_W (DATA_W),
        .EXP_A  (3),
        .EXP_B  (4),
        .EXP_C  (5),
        .EXP_D  (6)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .rst_req_o (rst_req_o)
    );

    task automatic check(input logic [2:0] exp, input int req, input string tag);
        checks++;
        if ({irq_o, fiq_o, rst_req_o} !== exp) begin
            errors++;
            $display("FAIL R%0d %s: {irq,fiq,rst} actual %b expected %b",
                     req, tag, {irq_o, fiq_o, rst_req_o}, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [11:0] d);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = {{(DATA_W-12){1'b0}}, d};
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check(3'b000, 1, "reset state");        // R1
        idle(50);
        check(3'b000, 1, "idle after reset");   // R1

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][28:27] == 2'd1) wr(1'b0, VEC[i][26:15]);
            else if (VEC[i][28:27] == 2'd2) wr(1'b1, VEC[i][26:15]);
            idle(int'(VEC[i][14:7]));
            check(VEC[i][6:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end

        // R10: service completes on the final count of the period
        wr(1'b0, 12'h000);
        wr(1'b0, 12'h001);
        idle(6);
        wr(1'b1, 12'h123);
        wr(1'b1, 12'h321);
        check(3'b000, 10, "collision edge");
        idle(7);
        check(3'b000, 10, "period after collision");
        idle(1);
        check(3'b100, 10, "expiry after collision");

        // R6: second key after disable/enable with tracker idle
        wr(1'b0, 12'h000);
        wr(1'b0, 12'h005);
        idle(4);
        wr(1'b1, 12'h321);
        idle(3);
        check(3'b001, 6, "lone key does not restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule